// File: doc/BRIEF.md
# Time-Slotted Shared Memory Arbiter

This block lets three agents share one word-wide memory: a processor port, a video fetcher that only reads, and a disk DMA engine that reads and writes. It does not arbitrate on requests. A free-running two-bit phase counter cuts the bus into four-clock frames. Each phase of a frame belongs to one owner for good: phases 0 and 2 belong to video, phase 1 to the processor and phase 3 to disk. A slot whose owner is idle stays idle.

The processor sees a four-clock access. It sets up in phase 0, the memory cycle runs in phase 1, the data returns in phase 2 and the acknowledge comes in phase 3. A processor request that first appears in a phase other than 0 gets wait states until the next frame begins. The processor therefore loses only the clocks by which it was out of step. The DMA ports get their acknowledge one clock after their slot.

The memory is synchronous. It takes its command in the clock where `mem_en` is high and returns read data on `mem_rdata` during the following clock.

Top module: `tsa_arbiter`

## Requirements
- R1: The phase counter is 0 in the first clock after reset is released and then steps 0,1,2,3 in a repeating cycle.
- R2: Phases 0 and 2 issue video reads, phase 1 issues the processor access and phase 3 issues the disk access. In the issuing clock, `mem_addr`, `mem_we` and `mem_wdata` carry the owner's values.
- R3: A slot whose owner has no request leaves `mem_en` and `mem_we` low, even when other ports are requesting. `mem_we` is never high without `mem_en`.
- R4: `vid_ack` and `dsk_ack` are one-clock pulses in the clock after their port's slot. On a read, the word read is present on `vid_rdata`/`dsk_rdata` in that clock.
- R5: A processor request raised in phase 0 and held is acknowledged in phase 3 of the same frame, four clocks after it is raised. A read returns the addressed word on `cpu_rdata` with the acknowledge.
- R6: A processor request first raised in phase p is acknowledged on its 4 + ((4 − p) mod 4)th clock. `cpu_ack` only ever occurs in phase 3.
- R7: Each port's read data stays unchanged except in a clock where that port's acknowledge is high. A write acknowledge leaves the port's read data as it was.
- R8: A write is committed in its owner's slot, and a later read by any port returns the written word. Video never causes a write, so `mem_we` is only ever high in phase 1 or 3.
- R9: While the synchronous active-low reset is applied, `mem_en`, `mem_we` and all acknowledges are low. Reset also clears every port's held read data to zero and any processor request waiting for its window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held until `cpu_ack` |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data, held between acknowledges |
| cpu_ack | output | 1 | Processor access complete (one clock) |
| vid_req | input | 1 | Video fetch request |
| vid_addr | input | AW | Video word address |
| vid_rdata | output | DW | Video read data |
| vid_ack | output | 1 | Video fetch complete (one clock) |
| dsk_req | input | 1 | Disk DMA request |
| dsk_we | input | 1 | Disk access is a write |
| dsk_addr | input | AW | Disk word address |
| dsk_wdata | input | DW | Disk write data |
| dsk_rdata | output | DW | Disk read data |
| dsk_ack | output | 1 | Disk access complete (one clock) |
| mem_en | output | 1 | Memory command valid this clock |
| mem_we | output | 1 | Memory command is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the clock after a read command |

## Verification
The assertions check on every clock the properties that depend only on one frame:
- each issued command comes from its phase's owner with that owner's address and direction;
- writes only ever occur in phase 1 or 3;
- each acknowledge has a matching slot one clock earlier, and the processor acknowledge falls in phase 3 after a held request;
- read data changes only while the port's acknowledge is high.

Only the bench scenarios can show the things that need a reference beyond the current frame:
- the exact number of wait clocks for each starting phase;
- data written by one port and read back by another;
- the data values themselves;
- the restart of the frame after a reset taken mid-traffic.

// File: rtl/tsa_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the time-slotted arbiter: frame geometry,
// slot owners and the fixed phase-to-owner schedule.
package tsa_pkg;

    localparam int PHASE_W   = 2;
    localparam int FRAME_LEN = 1 << PHASE_W;

    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic [1:0] {
        OWN_VID = 2'd0,
        OWN_CPU = 2'd1,
        OWN_DSK = 2'd2
    } owner_e;

    // Processor frame: it arms in phase 0 and issues in phase 1.
    localparam phase_t CPU_ARM_PHASE   = phase_t'(0);
    localparam phase_t CPU_ISSUE_PHASE = phase_t'(1);

    // Fixed schedule: 0 video, 1 processor, 2 video, 3 disk.
    function automatic owner_e slot_owner(input phase_t ph);
        case (ph)
            phase_t'(1): return OWN_CPU;
            phase_t'(3): return OWN_DSK;
            default:     return OWN_VID;
        endcase
    endfunction

endpackage

// File: rtl/tsa_phase_gen.sv
`timescale 1ns/1ps
// Phase sequencer.
// Free-running frame counter with a decoded slot owner.
// Assumes: reset holds phase 0, so the first clock after release is phase 0.
module tsa_phase_gen
    import tsa_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase,
    output owner_e owner
);

    phase_t phase_q;

    // Advance one phase per clock and wrap at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + phase_t'(1);
        end
    end

    // Decode the owner of the current slot.
    always_comb begin
        owner = slot_owner(phase_q);
    end

    assign phase = phase_q;

endmodule

// File: rtl/tsa_cpu_window.sv
`timescale 1ns/1ps
// Processor window tracker (wait-state insertion).
// A request only counts for a frame if it was present in the arm phase.
// A request raised later in the frame waits for the next frame.
// Assumes: the processor holds its request until acknowledged.
module tsa_cpu_window
    import tsa_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    input  logic   cpu_req,
    output logic   cpu_go
);

    logic armed_q;

    // Arm at frame start on a present request; disarm once the issue phase passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (phase == CPU_ARM_PHASE) begin
            armed_q <= cpu_req;
        end else if (phase == CPU_ISSUE_PHASE) begin
            armed_q <= 1'b0;
        end
    end

    // Issue only in the issue phase of a frame that was entered in step.
    always_comb begin
        cpu_go = rst_n && armed_q && cpu_req && (phase == CPU_ISSUE_PHASE);
    end

endmodule

// File: rtl/tsa_return_path.sv
`timescale 1ns/1ps
// Per-port return path.
// Generates the one-clock acknowledge and keeps the port's read data.
// LATE_ACK = 0: the acknowledge comes in the data clock and shows mem_rdata directly.
// LATE_ACK = 1: the data is registered first and the acknowledge comes one clock
// later (the processor's release clock).
// Assumes: memory read data is valid in the clock after the command.
module tsa_return_path #(
    parameter int DW       = 16,
    parameter bit LATE_ACK = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          issue_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic          ack,
    output logic [DW-1:0] rdata
);

    logic          dcyc_q;
    logic          rd_q;
    logic [DW-1:0] hold_q;

    // Mark the clock in which this port's memory data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcyc_q <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            dcyc_q <= issue;
            rd_q   <= issue && issue_rd;
        end
    end

    // Capture returned read data; writes leave the held word untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (dcyc_q && rd_q) begin
            hold_q <= mem_rdata;
        end
    end

    generate
        if (LATE_ACK) begin : g_late
            logic ack_q;

            // Delay the acknowledge into the clock after the data clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ack_q <= 1'b0;
                end else begin
                    ack_q <= dcyc_q;
                end
            end

            assign ack   = ack_q;
            assign rdata = hold_q;
        end else begin : g_early
            assign ack   = dcyc_q;
            assign rdata = (dcyc_q && rd_q) ? mem_rdata : hold_q;
        end
    endgenerate

endmodule

// File: rtl/tsa_arbiter.sv
`timescale 1ns/1ps
// Time-slotted shared memory arbiter (top).
// Steers one synchronous memory between the processor, video and disk ports
// using a fixed four-phase frame. Idle slots are never given to another port.
// Assumes: each requester holds its request and command fields until its
// acknowledge; memory returns read data one clock after the command.
module tsa_arbiter
    import tsa_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ack,
    input  logic          vid_req,
    input  logic [AW-1:0] vid_addr,
    output logic [DW-1:0] vid_rdata,
    output logic          vid_ack,
    input  logic          dsk_req,
    input  logic          dsk_we,
    input  logic [AW-1:0] dsk_addr,
    input  logic [DW-1:0] dsk_wdata,
    output logic [DW-1:0] dsk_rdata,
    output logic          dsk_ack,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    phase_t phase;
    owner_e owner;
    logic   cpu_go;
    logic   vid_go;
    logic   dsk_go;

    tsa_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .owner (owner)
    );

    tsa_cpu_window u_cpuwin (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .cpu_req (cpu_req),
        .cpu_go  (cpu_go)
    );

    // Grant the DMA ports in their own slots only.
    always_comb begin
        vid_go = rst_n && (owner == OWN_VID) && vid_req;
        dsk_go = rst_n && (owner == OWN_DSK) && dsk_req;
    end

    // Steer the granted port onto the memory; park the bus at zero when idle.
    always_comb begin
        mem_en    = cpu_go || vid_go || dsk_go;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (cpu_go) begin
            mem_we    = cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end else if (dsk_go) begin
            mem_we    = dsk_we;
            mem_addr  = dsk_addr;
            mem_wdata = dsk_wdata;
        end else if (vid_go) begin
            mem_addr  = vid_addr;
        end
    end

    tsa_return_path #(.DW(DW), .LATE_ACK(1'b1)) u_ret_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (cpu_go),
        .issue_rd  (!cpu_we),
        .mem_rdata (mem_rdata),
        .ack       (cpu_ack),
        .rdata     (cpu_rdata)
    );

    tsa_return_path #(.DW(DW), .LATE_ACK(1'b0)) u_ret_vid (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (vid_go),
        .issue_rd  (1'b1),
        .mem_rdata (mem_rdata),
        .ack       (vid_ack),
        .rdata     (vid_rdata)
    );

    tsa_return_path #(.DW(DW), .LATE_ACK(1'b0)) u_ret_dsk (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (dsk_go),
        .issue_rd  (!dsk_we),
        .mem_rdata (mem_rdata),
        .ack       (dsk_ack),
        .rdata     (dsk_rdata)
    );

endmodule

// File: rtl/tsa_checker.sv
`timescale 1ns/1ps
// Protocol checker for tsa_arbiter.
// Keeps its own phase count from reset and checks the schedule,
// acknowledge timing and data holding at the ports.
module tsa_checker #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic [AW-1:0] cpu_addr,
    input logic [DW-1:0] cpu_rdata,
    input logic          cpu_ack,
    input logic          vid_req,
    input logic [AW-1:0] vid_addr,
    input logic [DW-1:0] vid_rdata,
    input logic          vid_ack,
    input logic          dsk_req,
    input logic          dsk_we,
    input logic [AW-1:0] dsk_addr,
    input logic [DW-1:0] dsk_rdata,
    input logic          dsk_ack,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);

    logic [1:0] cnt;

    // Reference phase count: zero under reset, then one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= 2'd0;
        else        cnt <= cnt + 2'd1;
    end

    // R2: video slots carry the video address and read.
    a_r2_vid_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !cnt[0]) |-> (vid_req && mem_addr == vid_addr && !mem_we));

    // R2: the processor slot carries the processor command.
    a_r2_cpu_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && cnt == 2'd1) |-> (cpu_req && mem_addr == cpu_addr && mem_we == cpu_we));

    // R2: the disk slot carries the disk command.
    a_r2_dsk_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && cnt == 2'd3) |-> (dsk_req && mem_addr == dsk_addr && mem_we == dsk_we));

    // R3: no write strobe without a memory cycle.
    a_r3_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> !mem_we);

    // R3: an idle disk slot is not handed to anyone else.
    a_r3_dsk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 2'd3 && !dsk_req) |-> !mem_en);

    // R4: a video acknowledge follows a video slot cycle.
    a_r4_vid_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vid_ack |-> $past(mem_en && !cnt[0]));

    // R4: a disk acknowledge follows a disk slot cycle.
    a_r4_dsk_ack: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_ack |-> $past(mem_en && cnt == 2'd3));

    // R6: the processor acknowledge falls only in phase 3.
    a_r6_cpu_ack_phase: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> (cnt == 2'd3));

    // R6: the processor held its request through the whole access.
    a_r6_cpu_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> ($past(cpu_req, 1) && $past(cpu_req, 2) && $past(cpu_req, 3)));

    // R7: read data is held between acknowledges.
    a_r7_cpu_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack |-> $stable(cpu_rdata));
    a_r7_vid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_ack |-> $stable(vid_rdata));
    a_r7_dsk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dsk_ack |-> $stable(dsk_rdata));

    // R8: writes occur only in the processor or disk slots.
    a_r8_no_video_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cnt[0]);

endmodule

bind tsa_arbiter tsa_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_rdata (cpu_rdata),
    .cpu_ack   (cpu_ack),
    .vid_req   (vid_req),
    .vid_addr  (vid_addr),
    .vid_rdata (vid_rdata),
    .vid_ack   (vid_ack),
    .dsk_req   (dsk_req),
    .dsk_we    (dsk_we),
    .dsk_addr  (dsk_addr),
    .dsk_rdata (dsk_rdata),
    .dsk_ack   (dsk_ack),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
);

// File: tb/sim_tsa_arbiter.sv
`timescale 1ns/1ps
// Bench for tsa_arbiter.
// A table of frame-long request patterns is walked first, then directed tests
// cover misalignment, write/readback, holding and reset.
module sim_tsa_arbiter;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ack;
    logic          vid_req = 1'b0;
    logic [AW-1:0] vid_addr = '0;
    logic [DW-1:0] vid_rdata;
    logic          vid_ack;
    logic          dsk_req = 1'b0, dsk_we = 1'b0;
    logic [AW-1:0] dsk_addr = '0;
    logic [DW-1:0] dsk_wdata = '0;
    logic [DW-1:0] dsk_rdata;
    logic          dsk_ack;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    tsa_arbiter #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .vid_req(vid_req), .vid_addr(vid_addr), .vid_rdata(vid_rdata), .vid_ack(vid_ack),
        .dsk_req(dsk_req), .dsk_we(dsk_we), .dsk_addr(dsk_addr), .dsk_wdata(dsk_wdata),
        .dsk_rdata(dsk_rdata), .dsk_ack(dsk_ack),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Initial content of every memory word.
    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a, a ^ 8'hA5};
    endfunction

    // Synchronous memory model: read data valid the clock after the command.
    logic [DW-1:0] ram [256];
    logic [DW-1:0] ram_q = '0;
    initial for (int i = 0; i < 256; i++) ram[i] = pat(AW'(i));
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        ram_q <= ram[mem_addr];
        end
    end
    assign mem_rdata = ram_q;

    int  n_chk = 0;
    int  n_bad = 0;
    int  bph   = 0;
    bit  done  = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Move to 2 ns after the next rising edge and track the phase.
    task automatic tick();
        @(posedge clk);
        #2;
        bph = (bph + 1) % 4;
    endtask

    // Apply reset with traffic present, check idle outputs, release in phase 0.
    task automatic do_reset();
        rst_n = 1'b0;
        vid_req = 1'b1; dsk_req = 1'b1; cpu_req = 1'b1;
        repeat (3) @(posedge clk);
        #8;
        check("R9 mem_en in reset", 32'(mem_en), 0);
        check("R9 mem_we in reset", 32'(mem_we), 0);
        check("R9 acks in reset", 32'({cpu_ack, vid_ack, dsk_ack}), 0);
        check("R9 cpu_rdata cleared", 32'(cpu_rdata), 0);
        check("R9 vid_rdata cleared", 32'(vid_rdata), 0);
        vid_req = 1'b0; dsk_req = 1'b0; cpu_req = 1'b0;
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        bph = 0;
    endtask

    // Frame patterns {vid, dsk, cpu, cpu_we, dsk_we}.
    localparam logic [4:0] TBL [8] = '{
        5'b11100, 5'b00000, 5'b10110, 5'b01001,
        5'b11101, 5'b00100, 5'b10000, 5'b00000
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic          pd, pdw;
        logic [AW-1:0] pda;
        logic [DW-1:0] last_cpu, last_dsk;
        int            n;
        pd = 0; pdw = 0; pda = '0; last_cpu = '0; last_dsk = '0;

        do_reset();

        // ---- Table walk: one frame per entry ----
        for (int e = 0; e < 8; e++) begin
            logic v, d, c, cw, dw;
            logic [AW-1:0] va, da, ca;
            {v, d, c, cw, dw} = TBL[e];
            va = AW'(8'h10 + e); da = AW'(8'h40 + e); ca = AW'(8'h80 + e);
            for (int p = 0; p < 4; p++) begin
                vid_req = v; vid_addr = va;
                dsk_req = d; dsk_we = dw; dsk_addr = da; dsk_wdata = DW'(16'hD000 + e);
                cpu_req = c; cpu_we = cw; cpu_addr = ca; cpu_wdata = DW'(16'hC000 + e);
                #8;
                case (p)
                    0: begin
                        check("R1 phase0 video slot en", 32'(mem_en), 32'(v));
                        if (v) check("R2 phase0 addr", 32'(mem_addr), 32'(va));
                        check("R8 phase0 no write", 32'(mem_we), 0);
                        check("R4 dsk_ack after slot", 32'(dsk_ack), 32'(pd));
                        if (pd && !pdw) begin
                            check("R4 dsk_rdata", 32'(dsk_rdata), 32'(pat(pda)));
                            last_dsk = pat(pda);
                        end else if (pd) begin
                            check("R7 dsk write keeps rdata", 32'(dsk_rdata), 32'(last_dsk));
                        end
                        check("R4 vid_ack idle phase0", 32'(vid_ack), 0);
                        check("R6 no cpu_ack phase0", 32'(cpu_ack), 0);
                    end
                    1: begin
                        check("R3 phase1 cpu slot en", 32'(mem_en), 32'(c));
                        if (c) begin
                            check("R2 phase1 addr", 32'(mem_addr), 32'(ca));
                            check("R2 phase1 we", 32'(mem_we), 32'(cw));
                            if (cw) check("R8 cpu wdata", 32'(mem_wdata), 32'(16'hC000 + e));
                        end
                        check("R4 vid_ack phase1", 32'(vid_ack), 32'(v));
                        if (v) check("R4 vid_rdata phase1", 32'(vid_rdata), 32'(pat(va)));
                        check("R4 dsk_ack phase1", 32'(dsk_ack), 0);
                    end
                    2: begin
                        check("R2 phase2 video slot en", 32'(mem_en), 32'(v));
                        if (v) check("R2 phase2 addr", 32'(mem_addr), 32'(va));
                        check("R4 vid_ack phase2", 32'(vid_ack), 0);
                        check("R6 no cpu_ack phase2", 32'(cpu_ack), 0);
                    end
                    default: begin
                        check("R3 phase3 disk slot en", 32'(mem_en), 32'(d));
                        if (d) begin
                            check("R2 phase3 addr", 32'(mem_addr), 32'(da));
                            check("R2 phase3 we", 32'(mem_we), 32'(dw));
                            if (dw) check("R8 dsk wdata", 32'(mem_wdata), 32'(16'hD000 + e));
                        end
                        check("R4 vid_ack phase3", 32'(vid_ack), 32'(v));
                        check("R5 cpu_ack aligned", 32'(cpu_ack), 32'(c));
                        if (c) begin
                            if (!cw) last_cpu = pat(ca);
                            check("R5 cpu_rdata", 32'(cpu_rdata), 32'(last_cpu));
                        end
                    end
                endcase
                tick();
            end
            pd = d; pdw = dw; pda = da;
        end
        vid_req = 0; dsk_req = 0; cpu_req = 0;

        // ---- Misaligned processor requests ----
        for (int p = 0; p < 4; p++) begin
            while (bph != p) tick();
            cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(8'h90 + p);
            n = 1;
            #8;
            while (!cpu_ack && n < 16) begin
                tick(); n++; #8;
            end
            check(p == 0 ? "R5 aligned latency" : "R6 misaligned latency",
                  32'(n), 32'(4 + (4 - p) % 4));
            check("R6 misaligned cpu_rdata", 32'(cpu_rdata), 32'(pat(AW'(8'h90 + p))));
            tick();
            cpu_req = 1'b0;
        end

        // ---- Processor write, video readback ----
        while (bph != 0) tick();
        cpu_req = 1; cpu_we = 1; cpu_addr = 8'hC3; cpu_wdata = 16'hBEEF;
        repeat (3) tick();
        #8;
        check("R8 cpu write ack", 32'(cpu_ack), 1);
        check("R7 cpu write keeps rdata", 32'(cpu_rdata), 32'(pat(8'h93)));
        tick();
        cpu_req = 0; cpu_we = 0;
        vid_req = 1; vid_addr = 8'hC3;
        tick();
        vid_req = 0;
        #8;
        check("R8 video reads cpu write", 32'(vid_rdata), 32'(16'hBEEF));

        // ---- Disk write, processor readback, then hold ----
        while (bph != 3) tick();
        dsk_req = 1; dsk_we = 1; dsk_addr = 8'hC4; dsk_wdata = 16'h1234;
        tick();
        dsk_req = 0; dsk_we = 0;
        #8;
        check("R4 dsk write ack", 32'(dsk_ack), 1);
        tick();
        while (bph != 0) tick();
        cpu_req = 1; cpu_addr = 8'hC4;
        repeat (3) tick();
        #8;
        check("R8 cpu reads disk write", 32'(cpu_rdata), 32'(16'h1234));
        tick();
        cpu_req = 0;
        dsk_req = 1; dsk_addr = 8'h05;
        vid_req = 1; vid_addr = 8'h06;
        for (int k = 0; k < 6; k++) begin
            #8;
            check("R7 cpu_rdata held", 32'(cpu_rdata), 32'(16'h1234));
            tick();
        end
        // idle slot: processor silent, phase 1 must not issue
        while (bph != 1) tick();
        #8;
        check("R3 idle cpu slot not reassigned", 32'(mem_en), 0);
        tick();

        // ---- Reset mid-traffic and frame restart ----
        do_reset();
        vid_req = 1; vid_addr = 8'h07;
        cpu_req = 1; cpu_we = 0; cpu_addr = 8'h08;
        dsk_req = 0;
        #8;
        check("R1 restart phase0 video", 32'({mem_en, mem_addr}), 32'({1'b1, 8'h07}));
        tick(); #8;
        check("R1 restart phase1 cpu", 32'({mem_en, mem_addr}), 32'({1'b1, 8'h08}));
        tick(); #8;
        check("R1 restart phase2 video", 32'({mem_en, mem_addr}), 32'({1'b1, 8'h07}));
        tick(); #8;
        check("R3 idle disk slot", 32'(mem_en), 0);
        check("R5 cpu_ack after restart", 32'(cpu_ack), 1);
        check("R5 cpu_rdata after restart", 32'(cpu_rdata), 32'(pat(8'h08)));
        tick();
        vid_req = 0; cpu_req = 0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule